// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This peripheral keeps time as a plain 32-bit count of seconds and sits on a 32-bit APB-style register bus inside a 4 KB address window. A prescaler divides the bus clock by `CLK_PER_SEC` to make one tick per second, and the seconds count advances by one on every tick. Software can read the count, set it to any value, and arm an alarm value. An alarm raises a level-sensitive interrupt line when the count steps onto that value.

The interrupt register works both ways. Reading it returns the alarm state. Writing zero to it acknowledges the alarm, and writing any nonzero value raises the interrupt by hand. A separate elapsed-seconds register works as a stopwatch: any write to it restarts it from zero. Two constant words near the top of the window let software identify the block.

Every access completes with no wait states. An access is acted on only when it is a full 32-bit word.

Top module: `sec_rtc`

## Requirements
- R1: A word read at offset 0x000 returns the seconds count. The count advances by exactly one after every `CLK_PER_SEC` clocks, and writes to 0x000 are ignored.
- R2: The match register at offset 0x004 stores any 32-bit word written to it and returns that word on read. Its reset value is 0.
- R3: A word write of any nonzero value to offset 0x008 makes the interrupt active, and `irq_o` is high from the following cycle.
- R4: A word write of zero to offset 0x008 clears the interrupt, unless an alarm occurs in the same cycle.
- R5: A word read at offset 0x008 returns the interrupt state in bit 0 (1 = active) with bits 31..1 zero.
- R6: When the seconds count advances on a tick to a value equal to the match register, the interrupt becomes active. It stays active until it is cleared. Loading the count directly to the match value does not raise it.
- R7: If an alarm and a write of zero to 0x008 take effect at the same clock edge, the alarm wins and the interrupt stays active.
- R8: A word write to offset 0x00C sets the seconds count to the written value and restarts the prescaler phase. The next advance therefore comes `CLK_PER_SEC` clocks later. Reads of 0x00C return 0.
- R9: A word write to offset 0x010 restarts the elapsed counter. Reads of 0x010 return the seconds count minus the count captured at that write, so the first read afterwards returns 0.
- R10: Offset 0xFE0 reads 0x00041030 and offset 0xFD8 reads 0x000FFFFF.
- R11: Only accesses with `psize_i` = 2'b10 (32-bit) are acted on. Other sizes change no register, and reads of other sizes return 0.
- R12: Reads of unmapped offsets return 0 and writes to them change nothing. `prdata_o` is 0 outside a read access phase, and `pready_o` is always high.
- R13: After reset the seconds count, the match register, the elapsed base and the interrupt are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and time-base clock |
| rst_i | input | 1 | Synchronous reset, active high |
| psel_i | input | 1 | Block select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte offset in the 4 KB window |
| psize_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in the access phase |
| pready_o | output | 1 | Transfer complete, tied high |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The alarm event and a software acknowledge of zero can land on the same clock edge, and so can a tick and a load of the count. The bench lines these up by first loading the count with a known value, which fixes the prescaler phase. It then counts clock edges so that the acknowledge write commits on exactly the edge where the count steps onto the match value. It requires `irq_o` to be high after that edge, and a second acknowledge one transfer later to clear it. Count reads around a load check that the tick coinciding with the load is lost and that the first advance comes a full period later.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // register offsets inside the window
    localparam addr_t OFS_TIME  = 12'h000;
    localparam addr_t OFS_MATCH = 12'h004;
    localparam addr_t OFS_IRQ   = 12'h008;
    localparam addr_t OFS_LOAD  = 12'h00C;
    localparam addr_t OFS_ELAP  = 12'h010;
    localparam addr_t OFS_MASK  = 12'hFD8;
    localparam addr_t OFS_IDENT = 12'hFE0;

    localparam word_t IDENT_WORD = 32'h0004_1030;
    localparam word_t MASK_WORD  = 32'h000F_FFFF;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TIME,
        SEL_MATCH,
        SEL_IRQ,
        SEL_LOAD,
        SEL_ELAP,
        SEL_MASK,
        SEL_IDENT
    } reg_sel_e;

    typedef struct packed {
        logic  match_we;
        logic  irq_we;
        logic  load_we;
        logic  elap_we;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        word_t secs;
        word_t match;
        word_t base;
        logic  irq;
    } rtc_state_t;

    function automatic reg_sel_e decode_ofs(addr_t a);
        reg_sel_e s;
        case (a)
            OFS_TIME:  s = SEL_TIME;
            OFS_MATCH: s = SEL_MATCH;
            OFS_IRQ:   s = SEL_IRQ;
            OFS_LOAD:  s = SEL_LOAD;
            OFS_ELAP:  s = SEL_ELAP;
            OFS_MASK:  s = SEL_MASK;
            OFS_IDENT: s = SEL_IDENT;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic word_t elapsed_of(word_t secs, word_t base);
        return secs - base;
    endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/sec_rtc_timebase.sv
module sec_rtc_timebase
    import sec_rtc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  wr_req_t    wr_i,
    output rtc_state_t st_o,
    output logic       alarm_o
);
    rtc_state_t st_q;
    word_t      secs_nxt;
    word_t      secs_inc;

    assign secs_inc = st_q.secs + 32'd1;

    always_comb begin
        if (wr_i.load_we) begin
            secs_nxt = wr_i.data;
        end else if (tick_i) begin
            secs_nxt = secs_inc;
        end else begin
            secs_nxt = st_q.secs;
        end
    end

    // an alarm needs a real advance; a load onto the match value is not one
    assign alarm_o = tick_i && !wr_i.load_we && (secs_inc == st_q.match);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q.secs <= secs_nxt;
            if (wr_i.match_we) begin
                st_q.match <= wr_i.data;
            end
            if (wr_i.elap_we) begin
                st_q.base <= secs_nxt;
            end
            if (alarm_o) begin
                st_q.irq <= 1'b1;
            end else if (wr_i.irq_we) begin
                st_q.irq <= (wr_i.data != '0);
            end
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/sec_rtc_apb_if.sv
module sec_rtc_apb_if
    import sec_rtc_pkg::*;
(
    input  logic       psel_i,
    input  logic       penable_i,
    input  logic       pwrite_i,
    input  addr_t      paddr_i,
    input  logic [1:0] psize_i,
    input  word_t      pwdata_i,
    input  rtc_state_t st_i,
    output wr_req_t    wr_o,
    output word_t      prdata_o,
    output logic       pready_o
);
    logic     acc_ok;
    logic     do_wr;
    logic     do_rd;
    reg_sel_e sel;

    assign acc_ok = psel_i && penable_i && (psize_i == SIZE_WORD);
    assign do_wr  = acc_ok && pwrite_i;
    assign do_rd  = acc_ok && !pwrite_i;
    assign sel    = decode_ofs(paddr_i);

    always_comb begin
        wr_o          = '0;
        wr_o.data     = pwdata_i;
        wr_o.match_we = do_wr && (sel == SEL_MATCH);
        wr_o.irq_we   = do_wr && (sel == SEL_IRQ);
        wr_o.load_we  = do_wr && (sel == SEL_LOAD);
        wr_o.elap_we  = do_wr && (sel == SEL_ELAP);
    end

    always_comb begin
        prdata_o = '0;
        if (do_rd) begin
            case (sel)
                SEL_TIME:  prdata_o = st_i.secs;
                SEL_MATCH: prdata_o = st_i.match;
                SEL_IRQ:   prdata_o = {{(DATA_W-1){1'b0}}, st_i.irq};
                SEL_ELAP:  prdata_o = elapsed_of(st_i.secs, st_i.base);
                SEL_MASK:  prdata_o = MASK_WORD;
                SEL_IDENT: prdata_o = IDENT_WORD;
                default:   prdata_o = '0;
            endcase
        end
    end

    assign pready_o = 1'b1;

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int unsigned CLK_PER_SEC = 32768
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        psel_i,
    input  logic        penable_i,
    input  logic        pwrite_i,
    input  logic [11:0] paddr_i,
    input  logic [1:0]  psize_i,
    input  logic [31:0] pwdata_i,
    output logic [31:0] prdata_o,
    output logic        pready_o,
    output logic        irq_o
);
    logic       tick;
    logic       alarm_hit;
    wr_req_t    wr;
    rtc_state_t st;

    sec_rtc_apb_if u_bus (
        .psel_i    (psel_i),
        .penable_i (penable_i),
        .pwrite_i  (pwrite_i),
        .paddr_i   (paddr_i),
        .psize_i   (psize_i),
        .pwdata_i  (pwdata_i),
        .st_i      (st),
        .wr_o      (wr),
        .prdata_o  (prdata_o),
        .pready_o  (pready_o)
    );

    sec_rtc_prescaler #(.DIV(CLK_PER_SEC)) u_pre (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (wr.load_we),
        .tick_o    (tick)
    );

    sec_rtc_timebase u_tb (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick),
        .wr_i    (wr),
        .st_o    (st),
        .alarm_o (alarm_hit)
    );

    assign irq_o = st.irq;

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
    import sec_rtc_pkg::*;
(
    input logic        clk_i,
    input logic        rst_i,
    input logic        psel_i,
    input logic        penable_i,
    input logic        pwrite_i,
    input logic [11:0] paddr_i,
    input logic [1:0]  psize_i,
    input logic [31:0] pwdata_i,
    input logic [31:0] prdata_o,
    input logic        pready_o,
    input logic        irq_o,
    input logic        tick,
    input logic        alarm_hit,
    input logic        load_we,
    input logic [31:0] secs_q,
    input logic [31:0] match_q
);
    logic acc_w;
    logic acc_r;
    logic ack_wr;

    assign acc_w  = psel_i && penable_i && pwrite_i && (psize_i == SIZE_WORD);
    assign acc_r  = psel_i && penable_i && !pwrite_i && (psize_i == SIZE_WORD);
    assign ack_wr = acc_w && (paddr_i == OFS_IRQ);

    assert_ready_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        pready_o);

    assert_idle_rdata_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        !(psel_i && penable_i) |-> (prdata_o == '0));

    assert_force_set_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_wr && pwdata_i != '0) |=> irq_o);

    assert_ack_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_wr && pwdata_i == '0 && !alarm_hit) |=> !irq_o);

    assert_status_read_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_r && paddr_i == OFS_IRQ) |-> (prdata_o == {31'd0, irq_o}));

    assert_alarm_sets_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        alarm_hit |=> irq_o);

    assert_irq_holds_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !ack_wr) |=> irq_o);

    assert_tick_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick && !load_we) |=> (secs_q == 32'($past(secs_q) + 32'd1)));

    assert_no_tick_hold_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick && !load_we) |=> $stable(secs_q));

    assert_load_read_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_r && paddr_i == OFS_LOAD) |-> (prdata_o == '0));

    assert_part_write_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (psel_i && penable_i && pwrite_i && psize_i != SIZE_WORD) |=> $stable(match_q));

    assert_part_read_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (psel_i && penable_i && !pwrite_i && psize_i != SIZE_WORD) |-> (prdata_o == '0));

endmodule

bind sec_rtc sec_rtc_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .psize_i   (psize_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .pready_o  (pready_o),
    .irq_o     (irq_o),
    .tick      (tick),
    .alarm_hit (alarm_hit),
    .load_we   (wr.load_we),
    .secs_q    (st.secs),
    .match_q   (st.match)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [1:0]  psize = 2'b10;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // time model, anchored at the last load
    logic [31:0] load_val = '0;
    int          load_cyc = 0;
    int          elap_cyc = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mon_act;
    event        rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sec_rtc #(.CLK_PER_SEC(DIV)) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .psel_i    (psel),
        .penable_i (penable),
        .pwrite_i  (pwrite),
        .paddr_i   (paddr),
        .psize_i   (psize),
        .pwdata_i  (pwdata),
        .prdata_o  (prdata),
        .pready_o  (pready),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] secs_at(int c);
        return load_val + 32'((c - load_cyc) / DIV);
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", mon_act, 32'hDEAD_BEEF);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check(it.tag, mon_act, it.val);
            end
        end
    end

    task automatic apb(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] d, output logic [31:0] rd, output int acc);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; psize = sz; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd  = prdata;
        acc = cyc;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; psize = 2'b10;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz, output int acc);
        logic [31:0] dummy;
        apb(1'b1, a, sz, d, dummy, acc);
    endtask

    // kind 0: constant, 1: seconds count, 2: elapsed
    task automatic rd_exp(input logic [11:0] a, input logic [1:0] sz, input int kind,
                          input logic [31:0] val, input string tag);
        logic [31:0] r;
        int          acc;
        exp_t        it;
        apb(1'b0, a, sz, 32'd0, r, acc);
        case (kind)
            1:       it.val = secs_at(acc);
            2:       it.val = secs_at(acc) - secs_at(elap_cyc);
            default: it.val = val;
        endcase
        it.tag = tag;
        exp_q.push_back(it);
        mon_act = r;
        -> rd_ev;
        #0;
    endtask

    task automatic load(input logic [31:0] v);
        int acc;
        wr32(12'h00C, v, 2'b10, acc);
        load_val = v;
        load_cyc = acc + 1;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int acc;
        int lc;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        check("R13 irq after reset", {31'd0, irq}, 32'd0);
        check("R12 pready idle", {31'd0, pready}, 32'd1);
        check("R12 prdata idle", prdata, 32'd0);
        rd_exp(12'h004, 2'b10, 0, 32'd0, "R13 match reset");
        rd_exp(12'h008, 2'b10, 0, 32'd0, "R13 status reset");
        rd_exp(12'h00C, 2'b10, 0, 32'd0, "R8 load reads zero");

        // R1 seconds count and ignored writes
        load(32'd100);
        rd_exp(12'h000, 2'b10, 1, 0, "R1 time after load");
        idle(21);
        rd_exp(12'h000, 2'b10, 1, 0, "R1 time advanced");
        wr32(12'h000, 32'h1234_5678, 2'b10, acc);
        rd_exp(12'h000, 2'b10, 1, 0, "R1 write to time ignored");

        // R8 prescaler phase restart
        load(32'd900);
        lc = load_cyc;
        wait_until(lc + 5);
        rd_exp(12'h000, 2'b10, 1, 0, "R8 before first advance");
        rd_exp(12'h000, 2'b10, 1, 0, "R8 after first advance");
        rd_exp(12'h00C, 2'b10, 0, 32'd0, "R8 load still reads zero");

        // R2 match register
        wr32(12'h004, 32'hA5A5_1234, 2'b10, acc);
        rd_exp(12'h004, 2'b10, 0, 32'hA5A5_1234, "R2 match readback");
        wr32(12'h004, 32'hFFFF_FFFF, 2'b10, acc);
        rd_exp(12'h004, 2'b10, 0, 32'hFFFF_FFFF, "R2 match all ones");

        // R10 identification
        rd_exp(12'hFE0, 2'b10, 0, 32'h0004_1030, "R10 ident");
        rd_exp(12'hFD8, 2'b10, 0, 32'h000F_FFFF, "R10 mask");

        // R11 partial accesses
        wr32(12'h004, 32'h0000_0055, 2'b01, acc);
        rd_exp(12'h004, 2'b10, 0, 32'hFFFF_FFFF, "R11 half write to match ignored");
        rd_exp(12'h004, 2'b00, 0, 32'd0, "R11 byte read returns zero");
        rd_exp(12'hFE0, 2'b01, 0, 32'd0, "R11 half read of ident zero");
        wr32(12'h008, 32'd1, 2'b00, acc);
        check("R11 byte write to irq ignored", {31'd0, irq}, 32'd0);

        // R12 unmapped
        rd_exp(12'h020, 2'b10, 0, 32'd0, "R12 unmapped read");
        rd_exp(12'h002, 2'b10, 0, 32'd0, "R12 misaligned read");
        rd_exp(12'hFDC, 2'b10, 0, 32'd0, "R12 unmapped high read");
        wr32(12'h020, 32'h0, 2'b10, acc);
        rd_exp(12'h004, 2'b10, 0, 32'hFFFF_FFFF, "R12 unmapped write no effect");

        // R3 / R4 / R5 software force and acknowledge
        wr32(12'h008, 32'd5, 2'b10, acc);
        check("R3 forced irq", {31'd0, irq}, 32'd1);
        rd_exp(12'h008, 2'b10, 0, 32'd1, "R5 status active");
        wr32(12'h008, 32'd0, 2'b10, acc);
        check("R4 cleared irq", {31'd0, irq}, 32'd0);
        rd_exp(12'h008, 2'b10, 0, 32'd0, "R5 status clear");

        // R9 elapsed counter
        wr32(12'h010, 32'hFFFF, 2'b10, acc);
        elap_cyc = acc + 1;
        rd_exp(12'h010, 2'b10, 2, 0, "R9 elapsed restart");
        idle(30);
        rd_exp(12'h010, 2'b10, 2, 0, "R9 elapsed advanced");

        // R6 alarm on advance
        wr32(12'h004, 32'd502, 2'b10, acc);
        load(32'd500);
        lc = load_cyc;
        wait_until(lc + 10);
        check("R6 no alarm before match", {31'd0, irq}, 32'd0);
        wait_until(lc + 17);
        check("R6 alarm on match", {31'd0, irq}, 32'd1);
        idle(20);
        check("R6 alarm held", {31'd0, irq}, 32'd1);
        rd_exp(12'h008, 2'b10, 0, 32'd1, "R6 status after alarm");
        wr32(12'h008, 32'd0, 2'b10, acc);
        check("R6 alarm cleared", {31'd0, irq}, 32'd0);
        load(32'd502);
        idle(3);
        check("R6 load onto match no alarm", {31'd0, irq}, 32'd0);

        // R7 alarm and acknowledge on the same edge
        wr32(12'h004, 32'd702, 2'b10, acc);
        load(32'd700);
        lc = load_cyc;
        wait_until(lc + 13);
        wr32(12'h008, 32'd0, 2'b10, acc);
        check("R7 commit edge aligned", acc + 1, lc + 16);
        check("R7 alarm wins over clear", {31'd0, irq}, 32'd1);
        wr32(12'h008, 32'd0, 2'b10, acc);
        check("R7 later clear works", {31'd0, irq}, 32'd0);

        idle(2);
        check("R12 prdata idle at end", prdata, 32'd0);
        check("R12 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        finish_run();
    end

endmodule